// File: doc/BRIEF.md
# Fan-Out Interrupt Multiplexer

This block takes one shared bank of level-sensitive, active-high interrupt request lines and presents them to several independent output channels. Each source reaches every channel. Each channel applies its own enable mask, so one source can be steered to any subset of outputs. A channel output is high while at least one of its enabled sources is high. It falls again once those sources drop. No edge capture or latching is involved.

Software reaches the block through a small memory-mapped register port. Every channel owns one read/write enable register and one read-only status register. The status register shows which enabled sources are currently asserted for that channel. Software masks or unmasks a single source by reading the enable register, changing one bit and writing the whole word back. Source lines come from other clock domains, so each passes through a two-stage synchroniser before masking.

Top module: `irqmux_top`

## Requirements
- R1: While reset is held, and afterwards until an enable register is written, every channel output is low, and every enable register reads as zero.
- R2: The enable register of channel n sits at byte address 0x40*n + 0x10. It holds all 32 written bits exactly as written and reads back the same word, with no effect on any other channel's register.
- R3: The status register of channel n sits at byte address 0x40*n + 0x20. Its bit i reads as source i AND enable bit i of channel n, after the synchroniser delay.
- R4: Output n is high exactly when any status bit of channel n is high. A change on a source line reaches the outputs on the third rising clock edge after it, and not before.
- R5: Writing zero to the enable register of channel n forces output n low on the second rising edge after the write, whatever the sources do.
- R6: Writes to a status register change no register and no output.
- R7: A read of an address whose offset within its 0x40 window is neither 0x10 nor 0x20 returns zero.
- R8: Read data appears on the cycle after the request. In a cycle that follows no read request, the read-data bus is zero.
- R9: Sources are level-sensitive. When a source line drops, its status bits and any outputs that depend only on it clear three rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Interrupt request lines, level-sensitive, active high, asynchronous |
| reg_vld | input | 1 | Register access strobe, one access per cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 8 | One interrupt output per channel |

## Verification
A corrupted enable bit appears at the ports in two ways. It shows on the next read-back of that channel, and it shows three edges after a lone source on that bit rises, when the output of the wrong channel fires. The bench therefore walks a single active source over all 32 positions against a different mask per channel, so every mask bit of every channel is observed in isolation. A wrong synchroniser depth or a missing register stage shifts the output edge off the third clock. Each edge is sampled one cycle early as well as on time, so such a shift shows up within one source change.

// File: rtl/irqmux_pkg.sv
// Shared constants and types for the fan-out interrupt multiplexer.
// Assumes each channel occupies one power-of-two address window.
package irqmux_pkg;
    localparam int unsigned WIN_LOG2 = 6;          // 0x40-byte window per channel
    localparam logic [WIN_LOG2-1:0] EN_OFS   = 6'h10;
    localparam logic [WIN_LOG2-1:0] STAT_OFS = 6'h20;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EN   = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irqmux_sync.sv
// Multi-stage synchroniser for a bus of independent level signals.
// Assumes each bit is a slow level. No bus coherency is implied.
module irqmux_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the asynchronous inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqmux_chan.sv
// One output channel: enable mask, registered status word and registered output.
// Assumes src_i is already synchronous to clk.
module irqmux_chan #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               en_we_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] stat_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] stat_q;
    logic               irq_q;
    logic [NUM_SRC-1:0] masked;

    assign masked = src_i & en_q;

    // Hold the enable mask, replaced as a whole word on write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= wdata_i;
    end

    // Register the status word and the output from the same masked sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= masked;
            irq_q  <= |masked;
        end
    end

    assign en_o   = en_q;
    assign stat_o = stat_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/irqmux_regif.sv
// Register port decode: per-channel write strobes and registered read mux.
// Assumes one access per cycle. Unmapped reads return zero.
module irqmux_regif
    import irqmux_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 9
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             vld_i,
    input  logic                             wr_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [NUM_SRC-1:0]               wdata_i,
    input  logic [NUM_CH-1:0][NUM_SRC-1:0]   en_all_i,
    input  logic [NUM_CH-1:0][NUM_SRC-1:0]   stat_all_i,
    output logic [NUM_CH-1:0]                en_we_o,
    output logic [NUM_SRC-1:0]               rdata_o
);
    localparam int unsigned CH_W = ADDR_W - WIN_LOG2;

    logic [CH_W-1:0]     ch_idx;
    logic [WIN_LOG2-1:0] ofs;
    logic                ch_ok;
    reg_sel_e            sel;
    logic [NUM_SRC-1:0]  rd_val;
    logic [NUM_SRC-1:0]  rdata_q;

    assign ch_idx = addr_i[ADDR_W-1:WIN_LOG2];
    assign ofs    = addr_i[WIN_LOG2-1:0];
    assign ch_ok  = (32'(ch_idx) < NUM_CH);

    // Classify the addressed register.
    always_comb begin
        sel = SEL_NONE;
        if (vld_i && ch_ok) begin
            if (ofs == EN_OFS)        sel = SEL_EN;
            else if (ofs == STAT_OFS) sel = SEL_STAT;
        end
    end

    // One write strobe per channel enable register.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_we
        assign en_we_o[n] = wr_i && (sel == SEL_EN) && (ch_idx == CH_W'(n));
    end

    // Select the read word for the addressed register.
    always_comb begin
        rd_val = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_idx == CH_W'(n)) begin
                if (sel == SEL_EN)        rd_val = en_all_i[n];
                else if (sel == SEL_STAT) rd_val = stat_all_i[n];
            end
        end
    end

    // Return read data one cycle later, zero when no read was made.
    always_ff @(posedge clk) begin
        if (!rst_n)            rdata_q <= '0;
        else if (vld_i && !wr_i) rdata_q <= rd_val;
        else                   rdata_q <= '0;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/irqmux_top.sv
// Fan-out interrupt multiplexer top: synchronises the shared sources and
// presents them to NUM_CH independently masked channels.
// Assumes sources are level-sensitive, active high, and may be asynchronous.
module irqmux_top #(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned ADDR_W      = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_vld,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic [NUM_CH-1:0]  irq_o
);
    logic [NUM_SRC-1:0]             src_s;
    logic [NUM_CH-1:0]              en_we;
    logic [NUM_CH-1:0][NUM_SRC-1:0] en_all;
    logic [NUM_CH-1:0][NUM_SRC-1:0] stat_all;

    irqmux_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (src_s)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        irqmux_chan #(
            .NUM_SRC (NUM_SRC)
        ) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_s),
            .en_we_i (en_we[n]),
            .wdata_i (reg_wdata),
            .en_o    (en_all[n]),
            .stat_o  (stat_all[n]),
            .irq_o   (irq_o[n])
        );
    end

    irqmux_regif #(
        .NUM_CH  (NUM_CH),
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) regif_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (reg_vld),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .en_all_i   (en_all),
        .stat_all_i (stat_all),
        .en_we_o    (en_we),
        .rdata_o    (reg_rdata)
    );
endmodule

// File: rtl/irqmux_chk.sv
// Port-level property checker for irqmux_top, attached by bind below.
// Assumes the default synchroniser depth of two stages.
module irqmux_chk #(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               reg_vld,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic [NUM_SRC-1:0] reg_rdata,
    input logic [NUM_CH-1:0]  irq_o
);
    logic unmapped_rd;
    assign unmapped_rd = reg_vld && !reg_wr &&
                         (reg_addr[5:0] != 6'h10) && (reg_addr[5:0] != 6'h20);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0 && reg_rdata == '0));

    // R4
    src_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> (|$past(src_i, 3)));

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_rd |=> (reg_rdata == '0));

    // R8
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_vld && !reg_wr) |=> (reg_rdata == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_off
        // R5
        zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_vld && reg_wr && reg_addr == ADDR_W'(64*n + 16) && reg_wdata == '0)
            |=> ##1 !irq_o[n]);
    end
endmodule

bind irqmux_top irqmux_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
) chk_i (.*);

// File: tb/irqmux_top_tb_top.sv
module irqmux_top_tb_top;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        vld = 1'b0;
    logic        wr = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] en_m [NCH];

    always #4 clk = ~clk;

    irqmux_top dut_i (
        .clk (clk), .rst_n (rst_n), .src_i (src),
        .reg_vld (vld), .reg_wr (wr), .reg_addr (addr),
        .reg_wdata (wdata), .reg_rdata (rdata), .irq_o (irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
        vld = 1'b1; wr = 1'b1; addr = a; wdata = d;
        tick();
        vld = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [8:0] a, output logic [31:0] d);
        vld = 1'b1; wr = 1'b0; addr = a;
        tick();
        d = rdata;
        vld = 1'b0;
    endtask

    function automatic logic [7:0] exp_irq(input logic [31:0] s);
        logic [7:0] r;
        for (int n = 0; n < NCH; n++) r[n] = |(s & en_m[n]);
        return r;
    endfunction

    function automatic logic [8:0] en_a(input int n);
        return 9'(64 * n + 16);
    endfunction

    function automatic logic [8:0] st_a(input int n);
        return 9'(64 * n + 32);
    endfunction

    // Apply a source word and check output timing edge by edge, then status.
    task automatic apply_src(input logic [31:0] s, input string req);
        logic [7:0]  prev;
        logic [31:0] d;
        prev = exp_irq(src);
        src = s;
        tick(); tick();
        chk({req, " R4 early"}, 32'(irq), 32'(prev));
        tick();
        chk({req, " R4 edge3"}, 32'(irq), 32'(exp_irq(s)));
        for (int n = 0; n < NCH; n++) begin
            rd_reg(st_a(n), d);
            chk({req, " R3 status"}, d, s & en_m[n]);
        end
    endtask

    initial begin
        logic [31:0] d;
        for (int n = 0; n < NCH; n++) en_m[n] = '0;
        @(negedge clk);
        src = 32'hFFFF_FFFF;
        repeat (4) tick();
        chk("R1 irq in reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        src = '0;
        repeat (4) tick();
        chk("R1 irq after reset", 32'(irq), 32'h0);
        for (int n = 0; n < NCH; n++) begin
            rd_reg(en_a(n), d);
            chk("R1 enable reset", d, 32'h0);
        end

        // R2: distinct mask per channel, read back every one
        for (int n = 0; n < NCH; n++) begin
            en_m[n] = 32'h0101_0101 << n;
            wr_reg(en_a(n), en_m[n]);
        end
        for (int n = 0; n < NCH; n++) begin
            rd_reg(en_a(n), d);
            chk("R2 readback", d, en_m[n]);
        end

        // Walk one active source over every position
        for (int i = 0; i < 32; i++) apply_src(32'h1 << i, "walk");
        // R9: level drop clears
        apply_src(32'h0, "R9 drop");
        apply_src(32'hFFFF_FFFF, "ones");

        // Hashed masks and sources
        for (int n = 0; n < NCH; n++) begin
            en_m[n] = 32'h9E37_79B9 * (n + 3);
            wr_reg(en_a(n), en_m[n]);
            rd_reg(en_a(n), d);
            chk("R2 hashed readback", d, en_m[n]);
        end
        for (int k = 0; k < 12; k++) apply_src(32'h7F4A_7C15 * (k + 1) ^ (32'h1 << k), "hash");
        apply_src(32'h0, "R9 drop2");

        // R5: zero write turns the output off on the second edge
        en_m[5] = 32'hFFFF_FFFF;
        wr_reg(en_a(5), en_m[5]);
        apply_src(32'hFFFF_FFFF, "R5 setup");
        vld = 1'b1; wr = 1'b1; addr = en_a(5); wdata = '0;
        tick();
        vld = 1'b0; wr = 1'b0;
        chk("R5 one edge", 32'(irq[5]), 32'h1);
        tick();
        chk("R5 two edges", 32'(irq[5]), 32'h0);
        en_m[5] = '0;
        rd_reg(st_a(5), d);
        chk("R5 status", d, 32'h0);

        // R6: status writes ignored
        apply_src(32'h0, "R6 setup");
        wr_reg(st_a(2), 32'hFFFF_FFFF);
        repeat (3) tick();
        rd_reg(st_a(2), d);
        chk("R6 status", d, 32'h0);
        rd_reg(en_a(2), d);
        chk("R6 enable", d, en_m[2]);
        chk("R6 irq", 32'(irq), 32'h0);

        // R7: unmapped offsets
        apply_src(32'hFFFF_FFFF, "R7 setup");
        for (int o = 0; o < 64; o += 4) begin
            if (o != 16 && o != 32) begin
                rd_reg(9'(64 * 3 + o), d);
                chk("R7 unmapped", d, 32'h0);
            end
        end

        // R8: read timing and idle bus
        vld = 1'b1; wr = 1'b0; addr = en_a(1);
        @(posedge clk);
        #1;
        chk("R8 data after edge", rdata, en_m[1]);
        @(negedge clk);
        vld = 1'b0;
        tick();
        chk("R8 idle zero", rdata, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule